// File: doc/BRIEF.md
# Energy-Efficient Ethernet Port Control and Status Bank

This block keeps one 16-bit energy-efficient-Ethernet control and status word for each port of a small switch. A host never addresses these words directly. It writes a selector byte that names a register table and a port, writes an offset byte that names the high or low half of that port's word, and then moves one byte at a time through a single data window address. Reads of the selector, the offset or the window return their data on `bus_rdata` in the cycle after `bus_rd` is sampled.

Each word mixes three kinds of bit. Some are control bits that software writes and that reach the PHY side as levels. Some are live low-power-idle levels and a hardware status flag, which writes cannot change. Two are sticky flags that record low-power-idle signalling and clear when the low half is read. The auto-negotiation engine supplies a capability-match level. While hardware exchange is enabled, that level turns on 100BASE-T EEE without any software action. The PCS and the negotiation logic sit outside the block and appear only as input levels.

Top module: `eee_status_bank`

## Requirements
- R1: After reset, every port's high byte reads 0x80, its low byte reads 0x80 while the LPI and capability inputs are low, `eee10_dis` is all ones, `eee100_en` is all zeros, and the selector and offset bytes read 0x00.
- R2: A write to SEL_ADDR (default 0x6E) or OFS_ADDR (default 0x6F) stores the byte, which reads back unchanged. Read data appears on `bus_rdata` one cycle after the read, and `bus_rdata` holds its value while no read is issued.
- R3: The high byte sits at offset 0x2C. Its bit 7 is a writable 10BASE-T EEE disable (1 means disabled) that drives `eee10_dis`. Its bits 6..0 always read 0, and writes to them are ignored.
- R4: The low byte sits at offset 0x2D. Only its bits 7 (hardware exchange enable), 1 (software mode) and 0 (100BASE-T EEE enable, driving `eee100_en`) are writable. Writes to bits 6..2 are ignored.
- R5: Low-byte bits 4 and 2 show the level of `tx_lpi_now` and `rx_lpi_now` for that port in the cycle the read is sampled.
- R6: Low-byte bits 5 (transmit) and 3 (receive) become 1 in the cycle after the matching LPI level is high. They clear when the low byte is read through a valid window access. A read of the high byte leaves them unchanged.
- R7: If an LPI level is high in the same cycle as a clearing read, its sticky flag stays set.
- R8: While bit 7 of the low byte is 1 and `cap_match` for that port is high, bit 0 is set from the next cycle and bit 6 reads 1. Bit 6 reads 0 once `cap_match` drops. While bit 7 is 0, `cap_match` has no effect.
- R9: A window access whose selector bits 7..5 are not 3'b001, whose selector bits 3..0 are not 1 to 4, or whose offset is neither 0x2C nor 0x2D reads 0x00. It ignores writes and clears no sticky flag.
- R10: Selector port value n (1 to 4) reaches only port n-1 of the per-port inputs and outputs. A write to one port leaves every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the host access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| tx_lpi_now | input | NPORTS | Per-port live transmit LPI level |
| rx_lpi_now | input | NPORTS | Per-port live receive LPI level |
| cap_match | input | NPORTS | Per-port EEE capability match from negotiation |
| eee100_en | output | NPORTS | Per-port 100BASE-T EEE enable |
| eee10_dis | output | NPORTS | Per-port 10BASE-T EEE disable |

## Verification
The assertions assume that the host never asserts `bus_rd` and `bus_wr` in the same cycle and that the LPI and capability levels change only between clock edges. The stimulus keeps to both assumptions. It issues exactly one bus operation per cycle and drives every input on the falling edge. The sticky-flag properties also assume that an LPI level counts as an event in every cycle it is high. For that reason the bench holds levels for whole cycles and never produces sub-cycle pulses.

// File: rtl/eee_bank_pkg.sv
package eee_bank_pkg;
  localparam int BYTE_W   = 8;
  localparam int PORT_FW  = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  // table field lives in selector bits 7..5
  function automatic logic table_ok(byte_t sel, logic [2:0] id);
    return sel[7:5] == id;
  endfunction

  // port field lives in selector bits 3..0, valid range 1..nports
  function automatic logic port_ok(byte_t sel, int nports);
    return (sel[PORT_FW-1:0] != '0) && (int'(sel[PORT_FW-1:0]) <= nports);
  endfunction

  // low byte layout: hw_en, hw_stat, tx_seen, tx_now, rx_seen, rx_now, sw_mode, en100
  function automatic byte_t pack_lo(logic hw_en, logic hw_stat, logic tx_seen,
                                    logic tx_now, logic rx_seen, logic rx_now,
                                    logic sw_mode, logic en100);
    return {hw_en, hw_stat, tx_seen, tx_now, rx_seen, rx_now, sw_mode, en100};
  endfunction

  function automatic byte_t pack_hi(logic dis10);
    return {dis10, 7'b0};
  endfunction
endpackage

// File: rtl/eee_win_decode.sv
module eee_win_decode
  import eee_bank_pkg::*;
#(
  parameter int    NPORTS   = 4,
  parameter byte_t WIN_ADDR = 8'hA0,
  parameter logic [2:0] TABLE_ID = 3'b001,
  parameter byte_t OFS_HI   = 8'h2C,
  parameter byte_t OFS_LO   = 8'h2D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  byte_t             addr,
  input  byte_t             sel,
  input  byte_t             ofs,
  output logic [NPORTS-1:0] port_hit,
  output logic              hit_hi,
  output logic              hit_lo,
  output logic              win_ok
);
  logic sel_valid;
  logic ofs_valid;

  assign sel_valid = table_ok(sel, TABLE_ID) && port_ok(sel, NPORTS);
  assign ofs_valid = (ofs == OFS_HI) || (ofs == OFS_LO);
  assign win_ok    = (addr == WIN_ADDR) && sel_valid && ofs_valid;
  assign hit_hi    = win_ok && (ofs == OFS_HI);
  assign hit_lo    = win_ok && (ofs == OFS_LO);

  for (genvar i = 0; i < NPORTS; i++) begin : g_hit
    assign port_hit[i] = win_ok && (sel[PORT_FW-1:0] == PORT_FW'(i + 1));
  end

  // R9: at most one port is ever addressed
  a_r9_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_hit));

  // R9: a bad selector addresses no port
  a_r9_bad_sel_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[7:5] != TABLE_ID) |-> (port_hit == '0));
endmodule

// File: rtl/eee_port_reg.sv
module eee_port_reg
  import eee_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hi,
  input  logic  wr_lo,
  input  logic  rd_lo,
  input  byte_t wdata,
  input  logic  tx_now,
  input  logic  rx_now,
  input  logic  cap_match,
  output byte_t hi_byte,
  output byte_t lo_byte,
  output logic  eee100_en,
  output logic  eee10_dis
);
  logic dis10, hw_en, sw_mode, en100, hw_stat, tx_seen, rx_seen;
  logic hw_set;

  assign hw_set = hw_en && cap_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis10   <= 1'b1;
      hw_en   <= 1'b1;
      sw_mode <= 1'b0;
      en100   <= 1'b0;
      hw_stat <= 1'b0;
      tx_seen <= 1'b0;
      rx_seen <= 1'b0;
    end else begin
      if (wr_hi) dis10 <= wdata[7];
      if (wr_lo) begin
        hw_en   <= wdata[7];
        sw_mode <= wdata[1];
        en100   <= wdata[0];
      end
      if (hw_set) en100 <= 1'b1;
      hw_stat <= hw_set;
      tx_seen <= (tx_seen && !rd_lo) || tx_now;
      rx_seen <= (rx_seen && !rd_lo) || rx_now;
    end
  end

  assign hi_byte   = pack_hi(dis10);
  assign lo_byte   = pack_lo(hw_en, hw_stat, tx_seen, tx_now, rx_seen, rx_now, sw_mode, en100);
  assign eee100_en = en100;
  assign eee10_dis = dis10;

  // R6 / R7: a high level always leaves the flag set, even across a clearing read
  a_r7_tx_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_now |=> lo_byte[5]);
  a_r7_rx_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_now |=> lo_byte[3]);
  // R6: clearing read with no new event empties the flag
  a_r6_tx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !tx_now) |=> !lo_byte[5]);
  // R8: matched capability with hardware exchange on turns on 100BASE-T EEE
  a_r8_hw_sets_en: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_byte[7] && cap_match) |=> eee100_en);
  // R3: the disable bit moves only on a high-byte write
  a_r3_dis10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(eee10_dis));
endmodule

// File: rtl/eee_status_bank.sv
module eee_status_bank
  import eee_bank_pkg::*;
#(
  parameter int         NPORTS   = 4,
  parameter logic [7:0] SEL_ADDR = 8'h6E,
  parameter logic [7:0] OFS_ADDR = 8'h6F,
  parameter logic [7:0] WIN_ADDR = 8'hA0,
  parameter logic [2:0] TABLE_ID = 3'b001,
  parameter logic [7:0] OFS_HI   = 8'h2C,
  parameter logic [7:0] OFS_LO   = 8'h2D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPORTS-1:0] tx_lpi_now,
  input  logic [NPORTS-1:0] rx_lpi_now,
  input  logic [NPORTS-1:0] cap_match,
  output logic [NPORTS-1:0] eee100_en,
  output logic [NPORTS-1:0] eee10_dis
);
  byte_t sel_q, ofs_q, rdata_q, win_byte;
  logic [NPORTS-1:0] port_hit;
  logic hit_hi, hit_lo, win_ok;
  logic [NPORTS-1:0] wr_hi, wr_lo, rd_lo;
  byte_t hi_b [NPORTS];
  byte_t lo_b [NPORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      ofs_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == SEL_ADDR) sel_q <= bus_wdata;
      if (bus_addr == OFS_ADDR) ofs_q <= bus_wdata;
    end
  end

  eee_win_decode #(
    .NPORTS(NPORTS), .WIN_ADDR(WIN_ADDR), .TABLE_ID(TABLE_ID),
    .OFS_HI(OFS_HI), .OFS_LO(OFS_LO)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .sel(sel_q), .ofs(ofs_q),
    .port_hit(port_hit), .hit_hi(hit_hi), .hit_lo(hit_lo), .win_ok(win_ok)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign wr_hi[i] = bus_wr && port_hit[i] && hit_hi;
    assign wr_lo[i] = bus_wr && port_hit[i] && hit_lo;
    assign rd_lo[i] = bus_rd && port_hit[i] && hit_lo;

    eee_port_reg u_reg (
      .clk(clk), .rst_n(rst_n),
      .wr_hi(wr_hi[i]), .wr_lo(wr_lo[i]), .rd_lo(rd_lo[i]), .wdata(bus_wdata),
      .tx_now(tx_lpi_now[i]), .rx_now(rx_lpi_now[i]), .cap_match(cap_match[i]),
      .hi_byte(hi_b[i]), .lo_byte(lo_b[i]),
      .eee100_en(eee100_en[i]), .eee10_dis(eee10_dis[i])
    );
  end

  always_comb begin
    win_byte = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (port_hit[i]) win_byte = win_byte | (hit_hi ? hi_b[i] : lo_b[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (bus_addr == SEL_ADDR)      rdata_q <= sel_q;
      else if (bus_addr == OFS_ADDR) rdata_q <= ofs_q;
      else if (bus_addr == WIN_ADDR) rdata_q <= win_byte;
      else                           rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

  // R2: read data moves only when a read is issued
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R9: a rejected window read returns zero
  a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == WIN_ADDR && !win_ok) |=> (bus_rdata == 8'h00));
  // R3: high byte never shows reserved bits
  a_r3_hi_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_hi) |=> (bus_rdata[6:0] == 7'h00));
endmodule

// File: tb/eee_status_bank_test.sv
module eee_status_bank_test;
  localparam int NP = 4;
  localparam logic [7:0] A_SEL = 8'h6E, A_OFS = 8'h6F, A_WIN = 8'hA0;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0;
  logic [NP-1:0] tx_lpi_now = 0, rx_lpi_now = 0, cap_match = 0, eee100_en, eee10_dis;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eee_status_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_lpi_now(tx_lpi_now),
    .rx_lpi_now(rx_lpi_now), .cap_match(cap_match), .eee100_en(eee100_en),
    .eee10_dis(eee10_dis)
  );

  // {selector, offset, write data, expected readback}
  localparam logic [31:0] VEC [6] = '{
    32'h21_2D_FF_83,  // R4: only bits 7,1,0 take
    32'h22_2C_FF_80,  // R3: reserved bits stay zero
    32'h23_2C_00_00,  // R3: clear 10BASE-T disable
    32'h24_2D_7C_00,  // R4: read-only bits ignored
    32'h22_2D_01_01,  // R4
    32'h21_2C_7F_00   // R3
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic win_rd(logic [7:0] s, logic [7:0] o, output logic [7:0] d);
    wr(A_SEL, s); wr(A_OFS, o); rd(A_WIN, d);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 eee10_dis", 8'(eee10_dis), 8'h0F);
    check("R1 eee100_en", 8'(eee100_en), 8'h00);
    rd(A_SEL, d); check("R1 sel", d, 8'h00);
    for (int p = 1; p <= NP; p++) begin
      win_rd(8'h20 | 8'(p), 8'h2C, d); check("R1 hi", d, 8'h80);
      win_rd(8'h20 | 8'(p), 8'h2D, d); check("R1 lo", d, 8'h80);
    end
    wr(A_SEL, 8'h5A); rd(A_SEL, d); check("R2 sel readback", d, 8'h5A);
    wr(A_OFS, 8'h2C); rd(A_OFS, d); check("R2 ofs readback", d, 8'h2C);
    idle(2); check("R2 rdata held", bus_rdata, 8'h2C);

    for (int i = 0; i < 6; i++) begin
      wr(A_SEL, VEC[i][31:24]); wr(A_OFS, VEC[i][23:16]); wr(A_WIN, VEC[i][15:8]);
      rd(A_WIN, d);
      check("R3/R4 vector", d, VEC[i][7:0]);
    end
    check("R10 eee10_dis", 8'(eee10_dis), 8'h0A);
    check("R10 eee100_en", 8'(eee100_en), 8'h03);
    win_rd(8'h23, 8'h2D, d); check("R10 port3 lo untouched", d, 8'h80);

    // R5/R6/R7 on port 3
    @(negedge clk); tx_lpi_now[2] = 1; idle(2);
    win_rd(8'h23, 8'h2D, d); check("R5 tx live + R6 seen", d, 8'hB0);
    @(negedge clk); tx_lpi_now[2] = 0; idle(2);
    rd(A_WIN, d); check("R7 flag kept across read", d, 8'hA0);
    rd(A_WIN, d); check("R6 flag cleared", d, 8'h80);
    @(negedge clk); rx_lpi_now[2] = 1;
    @(negedge clk); rx_lpi_now[2] = 0;
    win_rd(8'h23, 8'h2C, d); check("R6 hi byte read", d, 8'h00);
    win_rd(8'h23, 8'h2D, d); check("R6 rx seen kept by hi read", d, 8'h88);
    rd(A_WIN, d); check("R6 rx cleared", d, 8'h80);
    @(negedge clk); rx_lpi_now[2] = 1; idle(1);
    rd(A_WIN, d); check("R5 rx live", d, 8'h8C);
    @(negedge clk); rx_lpi_now[2] = 0; idle(1);
    rd(A_WIN, d); rd(A_WIN, d); check("R6 rx cleared again", d, 8'h80);

    // R8
    @(negedge clk); cap_match[3] = 1; idle(3);
    win_rd(8'h24, 8'h2D, d); check("R8 no effect when hw off", d, 8'h00);
    @(negedge clk); cap_match[3] = 0;
    @(negedge clk); cap_match[2] = 1; idle(2);
    win_rd(8'h23, 8'h2D, d); check("R8 hw sets bit0 and bit6", d, 8'hC1);
    check("R8 eee100_en", 8'(eee100_en[2]), 8'h01);
    @(negedge clk); cap_match[2] = 0; idle(2);
    rd(A_WIN, d); check("R8 status drops", d, 8'h81);

    // R9
    @(negedge clk); tx_lpi_now[0] = 1;
    @(negedge clk); tx_lpi_now[0] = 0;
    win_rd(8'h41, 8'h2D, d); check("R9 bad table read", d, 8'h00);
    wr(A_WIN, 8'h00);
    win_rd(8'h20, 8'h2D, d); check("R9 port 0", d, 8'h00);
    win_rd(8'h25, 8'h2D, d); check("R9 port 5", d, 8'h00);
    win_rd(8'h21, 8'h2E, d); check("R9 bad offset", d, 8'h00);
    wr(A_WIN, 8'h00);
    win_rd(8'h21, 8'h2D, d); check("R9 no write, no clear", d, 8'hA3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule